// File: doc/BRIEF.md
# Interrupt Concentrator with Single-Request Arbitration

This block collects 64 level-sensitive interrupt lines and turns them into at most one outstanding interrupt request. The low 32 lines come from PCI slots and are gated in groups of four by eight mapping registers. The high 32 lines are on-board I/O sources, each gated by its own mapping register. Every mapping register carries one enable bit (bit 31) above 31 read-only identification bits.

Once a source is granted, its number is held and shown on a one-hot request vector until software releases it. Software releases it through a clear register, or by disabling the matching mapping register. Arbitration among pending sources runs only when the held request is released or a mapping register is written. It is not run on every cycle.

The register port is a plain single-cycle strobe with no back-pressure. An access is accepted in the cycle where `cfg_en` is high. Read data appears on `cfg_rdata` one clock later and holds until the next read. Interrupt lines and the request vector are levels and have no handshake.

Top module: `irq_concentrator`

## Requirements
- R1: Reset drops any held request (irq_req all zero), clears every enable bit and clears the sampled input state; bits 30:0 of the mapping registers are unaffected.
- R2: A PCI mapping register g sits at byte offsets 0x0C00–0x0C3F with g = offset[5:3], and an I/O mapping register i at 0x1000–0x107F with i = offset[7:3]. Both respond only when offset bit 2 is 1. A read returns {enable, fixed} with fixed = 0x7C0 | (g<<2) for PCI and 0x7E0 + i for I/O. Every other read returns zero, and read data appears the cycle after the access.
- R3: A mapping write changes only bit 31 and always re-arbitrates; a request already held is kept.
- R4: A mapping write with bit 31 = 0 drops the held request only when the held number equals the register index (PCI: index g; I/O: index i + 32).
- R5: Arbitration picks the lowest-numbered pending source whose mapping is enabled, so every PCI source (0–31) wins over every I/O source (32–63). It runs only on a mapping write or a released clear; an enabled pending source with nothing held and no such event stays unrequested.
- R6: A rising PCI line whose group (line>>2) is enabled claims the request in that cycle, even over a held one; among several, the lowest number wins. Rising edges are applied after a same-cycle register write.
- R7: A rising I/O line whose mapping is enabled claims the request only when nothing is held after the same-cycle write and no PCI line claimed.
- R8: A falling line only clears its sampled pending state; the held request is unchanged.
- R9: A write with offset bit 2 = 1 to 0x1400–0x14FF releases the held request when held>>2 equals offset[7:5], then re-arbitrates; otherwise it has no effect.
- R10: A write with offset bit 2 = 1 to 0x1800–0x1860 releases the held request only when held equals offset[7:3] | 0x20, then re-arbitrates; otherwise it has no effect.
- R11: irq_req is one-hot on the held number, or all zero when nothing is held, and it changes in the clock after the edge that caused the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 64 | Level interrupt lines; 0–31 PCI, 32–63 on-board I/O |
| cfg_en | input | 1 | Register access strobe |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 16 | Byte offset of the access |
| cfg_wdata | input | 32 | Write data; bit 31 is the enable |
| cfg_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_req | output | 64 | One-hot outstanding request, zero when none |

## Verification
The arbitration path is tried with several input patterns:
- a single isolated edge;
- simultaneous rises in two enabled PCI groups, which checks the lowest-number rule;
- a PCI rise while an I/O request is held, which checks the override;
- an I/O rise while a request is held, which checks the block;
- PCI and I/O sources pending together at a release, which checks the scan order.

Falling lines around a held request separate the pending state from the held state.

Disable writes aimed at the held source and at other sources separate the index-match rule from a plain enable change. Clear writes with matching and non-matching numbers check that only an exact owner releases.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_PCI_MAP,
    ACC_IO_MAP,
    ACC_PCI_CLR,
    ACC_IO_CLR
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e  kind;
    logic [4:0] idx;
    logic       en;
  } cfg_cmd_t;

  localparam logic [15:0] PCI_MAP_LO = 16'h0C00;
  localparam logic [15:0] PCI_MAP_HI = 16'h0C3F;
  localparam logic [15:0] IO_MAP_LO  = 16'h1000;
  localparam logic [15:0] IO_MAP_HI  = 16'h107F;
  localparam logic [15:0] PCI_CLR_LO = 16'h1400;
  localparam logic [15:0] PCI_CLR_HI = 16'h14FF;
  localparam logic [15:0] IO_CLR_LO  = 16'h1800;
  localparam logic [15:0] IO_CLR_HI  = 16'h1860;

  localparam int unsigned EN_BIT = 31;

  // Read-only identification bits of a mapping register.
  function automatic logic [30:0] pci_map_fixed(input int unsigned g);
    return 31'h7C0 | 31'(g << 2);
  endfunction

  function automatic logic [30:0] io_map_fixed(input int unsigned i);
    return 31'h7E0 + 31'(i);
  endfunction

endpackage

// File: rtl/irqc_lowest.sv
module irqc_lowest #(
  parameter int unsigned W  = 32,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          vld
);
  // Walk from the top down so the lowest set bit is the last one written.
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign vld = |vec;
endmodule

// File: rtl/irqc_cfg.sv
module irqc_cfg
  import irqc_pkg::*;
#(
  parameter int unsigned N_PCI_MAP = 8,
  parameter int unsigned N_IO_MAP  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_en,
  input  logic                 cfg_we,
  input  logic [15:0]          cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output cfg_cmd_t             cmd,
  output logic [N_PCI_MAP-1:0] pci_en_nxt,
  output logic [N_IO_MAP-1:0]  io_en_nxt,
  output logic [31:0]          cfg_rdata
);
  logic [N_PCI_MAP-1:0] pci_en_q;
  logic [N_IO_MAP-1:0]  io_en_q;
  acc_kind_e            acc_kind;
  logic [4:0]           acc_idx;
  logic [31:0]          rd_val;
  logic                 upper_half;

  assign upper_half = cfg_addr[2];

  // Address decode; only the upper word of each 64-bit slot responds.
  always_comb begin
    acc_kind = ACC_NONE;
    acc_idx  = '0;
    if (upper_half) begin
      if (cfg_addr >= PCI_MAP_LO && cfg_addr <= PCI_MAP_HI) begin
        acc_kind = ACC_PCI_MAP;
        acc_idx  = {2'b00, cfg_addr[5:3]};
      end else if (cfg_addr >= IO_MAP_LO && cfg_addr <= IO_MAP_HI) begin
        acc_kind = ACC_IO_MAP;
        acc_idx  = cfg_addr[7:3];
      end else if (cfg_addr >= PCI_CLR_LO && cfg_addr <= PCI_CLR_HI) begin
        acc_kind = ACC_PCI_CLR;
        acc_idx  = {2'b00, cfg_addr[7:5]};
      end else if (cfg_addr >= IO_CLR_LO && cfg_addr <= IO_CLR_HI) begin
        acc_kind = ACC_IO_CLR;
        acc_idx  = cfg_addr[7:3];
      end
    end
  end

  always_comb begin
    cmd.kind = (cfg_en && cfg_we) ? acc_kind : ACC_NONE;
    cmd.idx  = acc_idx;
    cmd.en   = cfg_wdata[EN_BIT];
  end

  // Only the enable bit is stored; bits 30:0 are fixed per register.
  for (genvar g = 0; g < N_PCI_MAP; g++) begin : g_pci_en
    assign pci_en_nxt[g] = (cmd.kind == ACC_PCI_MAP && cmd.idx == 5'(g))
                           ? cmd.en : pci_en_q[g];
    always_ff @(posedge clk) begin
      if (!rst_n) pci_en_q[g] <= 1'b0;
      else        pci_en_q[g] <= pci_en_nxt[g];
    end
  end

  for (genvar i = 0; i < N_IO_MAP; i++) begin : g_io_en
    assign io_en_nxt[i] = (cmd.kind == ACC_IO_MAP && cmd.idx == 5'(i))
                          ? cmd.en : io_en_q[i];
    always_ff @(posedge clk) begin
      if (!rst_n) io_en_q[i] <= 1'b0;
      else        io_en_q[i] <= io_en_nxt[i];
    end
  end

  always_comb begin
    rd_val = '0;
    if (acc_kind == ACC_PCI_MAP) begin
      for (int g = 0; g < int'(N_PCI_MAP); g++) begin
        if (acc_idx == 5'(g)) rd_val = {pci_en_q[g], pci_map_fixed(g)};
      end
    end else if (acc_kind == ACC_IO_MAP) begin
      for (int i = 0; i < int'(N_IO_MAP); i++) begin
        if (acc_idx == 5'(i)) rd_val = {io_en_q[i], io_map_fixed(i)};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 cfg_rdata <= '0;
    else if (cfg_en && !cfg_we) cfg_rdata <= rd_val;
  end

  // R2: a read of the lower word of a slot returns zero.
  a_r2_lower_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !cfg_we && !cfg_addr[2]) |=> (cfg_rdata == 32'h0));

  // R2: a read outside every mapping window returns zero.
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !cfg_we && cfg_addr >= PCI_CLR_LO) |=> (cfg_rdata == 32'h0));

endmodule

// File: rtl/irqc_hold.sv
module irqc_hold
  import irqc_pkg::*;
#(
  parameter int unsigned N_PCI_GRP = 8,
  parameter int unsigned GRP_SIZE  = 4,
  parameter int unsigned N_IO      = 32,
  localparam int unsigned N_PCI  = N_PCI_GRP * GRP_SIZE,
  localparam int unsigned N_SRC  = N_PCI + N_IO,
  localparam int unsigned IW     = $clog2(N_SRC + 1),
  localparam int unsigned GRP_SH = $clog2(GRP_SIZE),
  localparam int unsigned PW     = (N_PCI > 1) ? $clog2(N_PCI) : 1,
  localparam int unsigned OW     = (N_IO > 1) ? $clog2(N_IO) : 1,
  localparam int unsigned SW     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_SRC-1:0]     irq_lines,
  input  cfg_cmd_t             cmd,
  input  logic [N_PCI_GRP-1:0] pci_en_nxt,
  input  logic [N_IO-1:0]      io_en_nxt,
  output logic [IW-1:0]        held_q
);
  localparam logic [IW-1:0] NONE = IW'(N_SRC);

  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] src_en;
  logic [N_SRC-1:0] rise;
  logic [N_SRC-1:0] arb_vec;
  logic [SW-1:0]    arb_idx;
  logic             arb_vld;
  logic [PW-1:0]    prise_idx;
  logic             prise_vld;
  logic [OW-1:0]    orise_idx;
  logic             orise_vld;
  logic [IW-1:0]    held_wr;
  logic [IW-1:0]    held_arb;
  logic [IW-1:0]    held_nxt;
  logic             rearb;

  // Per-source enable, after this cycle's mapping write.
  for (genvar s = 0; s < N_SRC; s++) begin : g_src_en
    if (s < N_PCI) begin : g_pci
      assign src_en[s] = pci_en_nxt[s / GRP_SIZE];
    end else begin : g_io
      assign src_en[s] = io_en_nxt[s - N_PCI];
    end
  end

  assign rise    = irq_lines & ~pend_q;
  assign arb_vec = pend_q & src_en;

  irqc_lowest #(.W(N_SRC)) u_arb (
    .vec(arb_vec), .idx(arb_idx), .vld(arb_vld));

  irqc_lowest #(.W(N_PCI)) u_prise (
    .vec(rise[N_PCI-1:0] & src_en[N_PCI-1:0]), .idx(prise_idx), .vld(prise_vld));

  irqc_lowest #(.W(N_IO)) u_orise (
    .vec(rise[N_SRC-1:N_PCI] & src_en[N_SRC-1:N_PCI]), .idx(orise_idx), .vld(orise_vld));

  // Step 1: register write effects on the held request.
  always_comb begin
    held_wr = held_q;
    rearb   = 1'b0;
    unique case (cmd.kind)
      ACC_PCI_MAP: begin
        rearb = 1'b1;
        if (!cmd.en && held_q == IW'(cmd.idx)) held_wr = NONE;
      end
      ACC_IO_MAP: begin
        rearb = 1'b1;
        if (!cmd.en && held_q == IW'(cmd.idx) + IW'(N_PCI)) held_wr = NONE;
      end
      ACC_PCI_CLR: begin
        if (held_q != NONE && (held_q >> GRP_SH) == IW'(cmd.idx)) begin
          held_wr = NONE;
          rearb   = 1'b1;
        end
      end
      ACC_IO_CLR: begin
        if (held_q == IW'(cmd.idx) + IW'(N_PCI)) begin
          held_wr = NONE;
          rearb   = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // Step 2: re-arbitration over sampled pending lines when nothing is held.
  assign held_arb = (rearb && held_wr == NONE && arb_vld) ? IW'(arb_idx) : held_wr;

  // Step 3: edges; a PCI rise overrides, an I/O rise fills an empty slot.
  always_comb begin
    held_nxt = held_arb;
    if (prise_vld)                         held_nxt = IW'(prise_idx);
    else if (held_arb == NONE && orise_vld) held_nxt = IW'(N_PCI) + IW'(orise_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= NONE;
      pend_q <= '0;
    end else begin
      held_q <= held_nxt;
      pend_q <= irq_lines;
    end
  end

  // R5: without a register event or a rising edge the held request is stable.
  a_r5_no_event_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.kind == ACC_NONE && rise == '0) |=> $stable(held_q));

  // R6: an enabled PCI rise always leaves a PCI number held.
  a_r6_pci_rise_claims: assert property (@(posedge clk) disable iff (!rst_n)
    prise_vld |=> (held_q < IW'(N_PCI)));

  // R7: with something held and no PCI rise or register event, I/O edges change nothing.
  a_r7_io_rise_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q != NONE && cmd.kind == ACC_NONE && !prise_vld) |=> $stable(held_q));

  // R4: disabling the register that owns the held I/O request drops it.
  a_r4_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.kind == ACC_IO_MAP && !cmd.en && held_q == IW'(cmd.idx) + IW'(N_PCI) && !prise_vld)
    |=> (held_q != $past(held_q)));

  // R10: an I/O clear that names another number leaves a held request alone.
  a_r10_io_clear_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.kind == ACC_IO_CLR && held_q != NONE && held_q != IW'(cmd.idx) + IW'(N_PCI)
     && !prise_vld) |=> $stable(held_q));

endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator
  import irqc_pkg::*;
#(
  parameter int unsigned N_PCI_GRP = 8,
  parameter int unsigned GRP_SIZE  = 4,
  parameter int unsigned N_IO      = 32,
  localparam int unsigned N_SRC = N_PCI_GRP * GRP_SIZE + N_IO,
  localparam int unsigned IW    = $clog2(N_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_lines,
  input  logic             cfg_en,
  input  logic             cfg_we,
  input  logic [15:0]      cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic [N_SRC-1:0] irq_req
);
  cfg_cmd_t             cmd;
  logic [N_PCI_GRP-1:0] pci_en_nxt;
  logic [N_IO-1:0]      io_en_nxt;
  logic [IW-1:0]        held_q;

  irqc_cfg #(.N_PCI_MAP(N_PCI_GRP), .N_IO_MAP(N_IO)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cmd(cmd),
    .pci_en_nxt(pci_en_nxt), .io_en_nxt(io_en_nxt), .cfg_rdata(cfg_rdata));

  irqc_hold #(.N_PCI_GRP(N_PCI_GRP), .GRP_SIZE(GRP_SIZE), .N_IO(N_IO)) u_hold (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .cmd(cmd),
    .pci_en_nxt(pci_en_nxt), .io_en_nxt(io_en_nxt), .held_q(held_q));

  // R11: request vector decoded from the held number.
  for (genvar s = 0; s < N_SRC; s++) begin : g_req
    assign irq_req[s] = (held_q == IW'(s));
  end

  // R1: the cycle after reset no request is shown.
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (irq_req == '0));

endmodule

// File: tb/irq_concentrator_tb.sv
`timescale 1ns/1ps
module irq_concentrator_tb;

  typedef struct packed {
    logic [3:0]  rq;
    logic [1:0]  op;
    logic [15:0] addr;
    logic [31:0] wd;
    logic [63:0] irq;
    logic [6:0]  held;
    logic [31:0] rd;
  } vec_t;

  localparam logic [1:0] OP_IDLE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
  localparam logic [63:0] B1  = 64'h2,  B2 = 64'h4,  B5 = 64'h20,  B6 = 64'h40;
  localparam logic [63:0] B9  = 64'h200, B32 = 64'h1_0000_0000;
  localparam logic [31:0] EN  = 32'h8000_0000;
  localparam int N_ROWS = 35;

  localparam vec_t TBL [N_ROWS] = '{
    '{4'd2,  OP_RD,   16'h0C04, 32'h0, 64'h0, 7'd64, 32'h0000_07C0}, // R2 PCI map 0 readback
    '{4'd2,  OP_RD,   16'h101C, 32'h0, 64'h0, 7'd64, 32'h0000_07E3}, // R2 I/O map 3 readback
    '{4'd2,  OP_RD,   16'h0C00, 32'h0, 64'h0, 7'd64, 32'h0},         // R2 lower word reads zero
    '{4'd5,  OP_IDLE, 16'h0,    32'h0, B5,    7'd64, 32'h0},         // R5 disabled rise ignored
    '{4'd3,  OP_WR,   16'h0C0C, EN | 32'h123, B5, 7'd5, 32'h0},     // R3 enable group1, rearbitrate
    '{4'd3,  OP_RD,   16'h0C0C, 32'h0, B5,    7'd5,  32'h8000_07C4}, // R3 only bit31 changed
    '{4'd3,  OP_WR,   16'h1004, EN,    B5,    7'd5,  32'h0},         // R3 held kept on write
    '{4'd7,  OP_IDLE, 16'h0,    32'h0, B5|B32, 7'd5, 32'h0},         // R7 I/O rise blocked
    '{4'd8,  OP_IDLE, 16'h0,    32'h0, B32,   7'd5,  32'h0},         // R8 fall keeps held
    '{4'd9,  OP_WR,   16'h1424, 32'h0, B32,   7'd32, 32'h0},         // R9 group clear, rearb to I/O
    '{4'd10, OP_WR,   16'h180C, 32'h0, B32,   7'd32, 32'h0},         // R10 mismatch no release
    '{4'd8,  OP_IDLE, 16'h0,    32'h0, 64'h0, 7'd32, 32'h0},         // R8 fall keeps held
    '{4'd10, OP_WR,   16'h1804, 32'h0, 64'h0, 7'd64, 32'h0},         // R10 exact clear
    '{4'd7,  OP_IDLE, 16'h0,    32'h0, B32,   7'd32, 32'h0},         // R7 I/O rise into empty slot
    '{4'd6,  OP_IDLE, 16'h0,    32'h0, B32|B6, 7'd6, 32'h0},         // R6 PCI rise overrides
    '{4'd4,  OP_WR,   16'h0C0C, 32'h0, B32|B6, 7'd6, 32'h0},         // R4 index 1 != held 6
    '{4'd3,  OP_RD,   16'h0C0C, 32'h0, B32|B6, 7'd6, 32'h0000_07C4}, // R3 enable cleared
    '{4'd4,  OP_WR,   16'h1004, 32'h0, B32|B6, 7'd6, 32'h0},         // R4 I/O 0 != held 6
    '{4'd9,  OP_WR,   16'h1424, 32'h0, B32|B6, 7'd64, 32'h0},        // R9 release, nothing enabled
    '{4'd3,  OP_WR,   16'h1004, EN,    B32|B6, 7'd32, 32'h0},        // R3 write rearbitrates
    '{4'd4,  OP_WR,   16'h1004, 32'h0, B32|B6, 7'd64, 32'h0},        // R4 owner disabled, dropped
    '{4'd5,  OP_WR,   16'h0C04, EN,    B32|B6, 7'd64, 32'h0},        // R5 no enabled pending
    '{4'd5,  OP_WR,   16'h0C14, EN,    B32|B6, 7'd64, 32'h0},        // R5 group2 on, none pending
    '{4'd6,  OP_IDLE, 16'h0,    32'h0, B32|B6|B9|B2, 7'd2, 32'h0},   // R6 two rises, lowest wins
    '{4'd8,  OP_IDLE, 16'h0,    32'h0, B32|B6|B9, 7'd2, 32'h0},      // R8 fall keeps held
    '{4'd9,  OP_WR,   16'h1404, 32'h0, B32|B6|B9, 7'd9, 32'h0},      // R9 release, pick 9
    '{4'd3,  OP_WR,   16'h1004, EN,    B32|B6|B9, 7'd9, 32'h0},      // R3 held kept
    '{4'd8,  OP_IDLE, 16'h0,    32'h0, B32|B6, 7'd9, 32'h0},         // R8 fall keeps held
    '{4'd9,  OP_WR,   16'h1444, 32'h0, B32|B6, 7'd32, 32'h0},        // R9 group2 release
    '{4'd6,  OP_IDLE, 16'h0,    32'h0, B32|B6|B1, 7'd1, 32'h0},      // R6 PCI rise over I/O
    '{4'd4,  OP_WR,   16'h0C04, 32'h0, B32|B6|B1, 7'd1, 32'h0},      // R4 index 0 != held 1
    '{4'd3,  OP_WR,   16'h0C04, EN,    B32|B6|B1, 7'd1, 32'h0},      // R3 re-enable
    '{4'd5,  OP_WR,   16'h1404, 32'h0, B32|B6|B1, 7'd1, 32'h0},      // R5 PCI 1 before I/O 32
    '{4'd2,  OP_RD,   16'h1004, 32'h0, B32|B6|B1, 7'd1, 32'h8000_07E0}, // R2 I/O map 0
    '{4'd2,  OP_RD,   16'h1404, 32'h0, B32|B6|B1, 7'd1, 32'h0}       // R2 clear reads zero
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_lines = '0;
  logic        cfg_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [63:0] irq_req;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_concentrator u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .cfg_en(cfg_en),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_req(irq_req));

  function automatic logic [63:0] req_of(input logic [6:0] h);
    return (h >= 7'd64) ? 64'h0 : (64'h1 << h);
  endfunction

  task automatic check_req(input int rq, input logic [6:0] h, input string what);
    total++;
    if (irq_req !== req_of(h)) begin
      bad++;
      $display("FAIL R%0d %s: irq_req act=%h exp=%h", rq, what, irq_req, req_of(h));
    end
  endtask

  task automatic check_rd(input int rq, input logic [31:0] e, input string what);
    total++;
    if (cfg_rdata !== e) begin
      bad++;
      $display("FAIL R%0d %s: cfg_rdata act=%h exp=%h", rq, what, cfg_rdata, e);
    end
  endtask

  // Drive at a falling edge, let one rising edge act, check at the next falling edge.
  task automatic step(input vec_t v, input string what);
    cfg_en    = (v.op != OP_IDLE);
    cfg_we    = (v.op == OP_WR);
    cfg_addr  = v.addr;
    cfg_wdata = v.wd;
    irq_lines = v.irq;
    @(posedge clk);
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_we = 1'b0;
    check_req(int'(v.rq), v.held, what);       // R11 latency and one-hot on every step
    if (v.op == OP_RD) check_rd(int'(v.rq), v.rd, what);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while and right after reset
    check_req(1, 7'd64, "reset request");
    check_rd(1, 32'h0, "reset rdata");
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < N_ROWS; r++) begin
      step(TBL[r], $sformatf("row %0d", r));
    end

    // R1: reset with a request held, then check enables and request are cleared.
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_req(1, 7'd64, "reset drops held");
    rst_n = 1'b1;
    step('{4'd1, OP_RD, 16'h0C04, 32'h0, B32|B6|B1, 7'd64, 32'h0000_07C0}, "R1 enable cleared pci");
    step('{4'd1, OP_RD, 16'h1004, 32'h0, B32|B6|B1, 7'd64, 32'h0000_07E0}, "R1 enable cleared io");
    step('{4'd2, OP_RD, 16'h2004, 32'h0, B32|B6|B1, 7'd64, 32'h0}, "R2 unmapped");
    step('{4'd2, OP_RD, 16'h1084, 32'h0, B32|B6|B1, 7'd64, 32'h0}, "R2 past I/O window");
    step('{4'd2, OP_RD, 16'h0C3C, 32'h0, B32|B6|B1, 7'd64, 32'h0000_07DC}, "R2 last PCI map");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule